// File: doc/BRIEF.md
# JTAG-to-SPI Bridge Register

This block is the data register behind a user-defined JTAG instruction. It turns one long data-register shift into one SPI flash transaction. The host shifts a framed bit stream in on TDI. Any number of zero bits may come first, because bypassed TAPs ahead of this one push stale bits out before the real frame arrives. The first 1 bit starts the frame. A 32-bit transfer length follows. After that, the block runs exactly that many SPI clocks with chip select low and passes TDI straight through to MOSI. Any further shift cycles are accepted and do nothing, so the returned data can travel through the bypass registers further down the chain.

The register the chain sees is one bit deep, so the block adds only a single TCK of delay to the scan path. During the transfer, that bit captures MISO on each SPI rising edge and presents it on TDO. The host shifts MOSI data in and reads the flash's reply back in the same scan, offset only by the number of enabled TAPs.

The serial stream cannot stall, so there is no back-pressure. The host must supply one bit per TCK, and the flash must answer in the same cycle. SPI runs in mode 0: SCK idles low, MOSI changes after the falling edge of TCK and MISO is sampled on the rising edge.

Top module: `jspi_bridge`

## Requirements
- R1: While shifting and no frame has started, zero bits on TDI are ignored. CS_N stays high and SCK stays low.
- R2: The first 1 bit seen while shifting is the start marker. It counts neither as a length bit nor as a data bit.
- R3: The next 32 TDI bits form the transfer length L, most significant bit first.
- R4: After the last length bit, CS_N goes low and SCK gives exactly L rising edges. CS_N is low only during those cycles.
- R5: During the transfer, MOSI follows TDI. The flash receives the L bits that were shifted in right after the length, in order.
- R6: The one-bit register captures MISO on each TCK rising edge that carries an SPI clock, and drives it on TDO until the next edge. On every other shift cycle it holds the TDI bit of that cycle. A capture cycle clears it to 0.
- R7: Once L SPI clocks are done, further shift cycles leave CS_N high and produce no SCK edge until the frame is abandoned.
- R8: A length of zero ends the frame at once. CS_N is never asserted and no SCK edge occurs.
- R9: Leaving the shift state, deselecting the instruction, or a TAP reset returns the block to marker hunting. CS_N rises, and the next frame is parsed from the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | JTAG test clock |
| tap_reset | input | 1 | TAP test-logic reset, active high, asynchronous |
| dr_select | input | 1 | The user instruction that selects this register is active |
| dr_capture | input | 1 | TAP is in the capture-DR state |
| dr_shift | input | 1 | TAP is in the shift-DR state |
| tdi | input | 1 | Serial data in from the JTAG chain |
| tdo | output | 1 | Serial data out of the one-bit register |
| spi_sck | output | 1 | SPI clock, a gated copy of TCK |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |

## Verification
The checker watches every TCK edge and covers these points:
- the framer's state steps: hunt to length on a marker, the length-bit count, the countdown, the sticky done state, and the return to hunt on abort
- chip select staying aligned with the transfer state
- the one-bit register taking MISO during a transfer and TDI at all other times

Some properties need a whole frame to show, and only the bench scenarios cover them:
- the exact number of SCK edges for each length
- the bit order of the length
- the data order the flash receives
- the zero-length frame

The bench sweeps leading-zero counts against lengths 0 to 9 and runs one longer frame. It also aborts a transfer in three ways (shift dropped, instruction deselected, TAP reset) and checks that the next frame parses cleanly.

// File: rtl/jspi_pkg.sv
package jspi_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_LEN  = 2'd1,
    ST_XFER = 2'd2,
    ST_DONE = 2'd3
  } jspi_state_e;
endpackage

// File: rtl/jspi_framer.sv
module jspi_framer
  import jspi_pkg::*;
#(
  parameter int LEN_W = 32,
  localparam int BIT_W = $clog2(LEN_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              din,
  input  logic              cnt_last,
  output jspi_state_e       st,
  output logic [BIT_W-1:0]  bitc,
  output logic              load,
  output logic [LEN_W-1:0]  load_val
);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(LEN_W - 1);

  logic [LEN_W-1:0] len_sr;
  logic             len_end;

  // length register with the incoming bit appended
  assign load_val = {len_sr[LEN_W-2:0], din};
  assign len_end  = run && (st == ST_LEN) && (bitc == BIT_LAST);
  assign load     = len_end && (load_val != '0);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st     <= ST_HUNT;
      bitc   <= '0;
      len_sr <= '0;
    end else if (!run) begin
      st     <= ST_HUNT;
      bitc   <= '0;
      len_sr <= '0;
    end else begin
      unique case (st)
        ST_HUNT: begin
          if (din) begin
            st   <= ST_LEN;
            bitc <= '0;
          end
        end
        ST_LEN: begin
          len_sr <= load_val;
          bitc   <= bitc + 1'b1;
          if (len_end) st <= (load_val == '0) ? ST_DONE : ST_XFER;
        end
        ST_XFER: begin
          if (cnt_last) st <= ST_DONE;
        end
        ST_DONE: st <= ST_DONE;
        default: st <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/jspi_xfer_cnt.sv
module jspi_xfer_cnt
  import jspi_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  jspi_state_e      st,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  output logic [LEN_W-1:0] remain,
  output logic             cnt_last
);
  assign cnt_last = (remain == LEN_W'(1));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      remain <= '0;
    end else if (!run) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (st == ST_XFER && remain != '0) begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/jspi_spi_phy.sv
module jspi_spi_phy
  import jspi_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        run,
  input  logic        capture,
  input  jspi_state_e st,
  input  logic        din,
  input  logic        miso,
  output logic        dout,
  output logic        sck,
  output logic        cs_n,
  output logic        mosi
);
  logic active_q;
  logic dr_q;

  // window opens and closes on the falling edge so SCK never glitches
  always_ff @(negedge clk or posedge rst) begin
    if (rst) active_q <= 1'b0;
    else     active_q <= (st == ST_XFER) && run;
  end

  assign cs_n = ~active_q;
  assign sck  = clk & active_q & run;
  assign mosi = active_q & din;

  // the single scan stage
  always_ff @(posedge clk or posedge rst) begin
    if (rst)          dr_q <= 1'b0;
    else if (capture) dr_q <= 1'b0;
    else if (run)     dr_q <= (st == ST_XFER) ? miso : din;
  end

  assign dout = dr_q;
endmodule

// File: rtl/jspi_bridge.sv
module jspi_bridge
  import jspi_pkg::*;
#(
  parameter int LEN_W = 32,
  localparam int BIT_W = $clog2(LEN_W)
) (
  input  logic tck,
  input  logic tap_reset,
  input  logic dr_select,
  input  logic dr_capture,
  input  logic dr_shift,
  input  logic tdi,
  output logic tdo,
  output logic spi_sck,
  output logic spi_cs_n,
  output logic spi_mosi,
  input  logic spi_miso
);
  logic             run;
  logic             cap;
  jspi_state_e      st;
  logic [BIT_W-1:0] bitc;
  logic             load;
  logic [LEN_W-1:0] load_val;
  logic [LEN_W-1:0] remain;
  logic             cnt_last;

  assign run = dr_select & dr_shift;
  assign cap = dr_select & dr_capture;

  jspi_framer #(.LEN_W(LEN_W)) u_framer (
    .clk(tck), .rst(tap_reset), .run(run), .din(tdi), .cnt_last(cnt_last),
    .st(st), .bitc(bitc), .load(load), .load_val(load_val)
  );

  jspi_xfer_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk(tck), .rst(tap_reset), .run(run), .st(st), .load(load),
    .load_val(load_val), .remain(remain), .cnt_last(cnt_last)
  );

  jspi_spi_phy u_phy (
    .clk(tck), .rst(tap_reset), .run(run), .capture(cap), .st(st),
    .din(tdi), .miso(spi_miso), .dout(tdo), .sck(spi_sck),
    .cs_n(spi_cs_n), .mosi(spi_mosi)
  );
endmodule

// File: rtl/jspi_bridge_chk.sv
module jspi_bridge_chk
  import jspi_pkg::*;
#(
  parameter int LEN_W = 32,
  localparam int BIT_W = $clog2(LEN_W)
) (
  input logic             tck,
  input logic             tap_reset,
  input logic             run,
  input logic             cap,
  input logic             tdi,
  input logic             tdo,
  input logic             spi_miso,
  input logic             spi_cs_n,
  input jspi_state_e      st,
  input logic [BIT_W-1:0] bitc,
  input logic [LEN_W-1:0] remain
);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(LEN_W - 1);

  assert_zero_stays_hunt_R1: assert property (@(posedge tck) disable iff (tap_reset)
    (run && st == ST_HUNT && !tdi) |=> (st == ST_HUNT));

  assert_marker_opens_len_R2: assert property (@(posedge tck) disable iff (tap_reset)
    (run && st == ST_HUNT && tdi) |=> (st == ST_LEN && bitc == '0));

  assert_len_bit_count_R3: assert property (@(posedge tck) disable iff (tap_reset)
    (run && st == ST_LEN && bitc != BIT_LAST) |=> (st == ST_LEN && bitc == $past(bitc) + 1'b1));

  assert_cs_matches_xfer_R4: assert property (@(posedge tck) disable iff (tap_reset)
    ((st == ST_XFER) == !spi_cs_n));

  assert_countdown_R4: assert property (@(posedge tck) disable iff (tap_reset)
    (run && st == ST_XFER && remain > LEN_W'(1)) |=> (st == ST_XFER && remain == $past(remain) - 1'b1));

  assert_miso_to_tdo_R6: assert property (@(posedge tck) disable iff (tap_reset)
    (run && !cap && st == ST_XFER) |=> (tdo == $past(spi_miso)));

  assert_bypass_stage_R6: assert property (@(posedge tck) disable iff (tap_reset)
    (run && !cap && st != ST_XFER) |=> (tdo == $past(tdi)));

  assert_done_sticky_R7: assert property (@(posedge tck) disable iff (tap_reset)
    (run && st == ST_DONE) |=> (st == ST_DONE && spi_cs_n));

  assert_abort_clears_R9: assert property (@(posedge tck) disable iff (tap_reset)
    (!run) |=> (st == ST_HUNT && remain == '0));
endmodule

bind jspi_bridge jspi_bridge_chk #(.LEN_W(LEN_W)) u_chk (
  .tck(tck), .tap_reset(tap_reset), .run(run), .cap(cap), .tdi(tdi),
  .tdo(tdo), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .st(st),
  .bitc(bitc), .remain(remain)
);

// File: tb/jspi_bridge_tb.sv
`timescale 1ns/1ps
module jspi_bridge_tb;
  logic tck = 1'b0;
  always #4 tck = ~tck;

  logic tap_reset = 1'b1;
  logic dr_select = 1'b0;
  logic dr_capture = 1'b0;
  logic dr_shift = 1'b0;
  logic tdi = 1'b0;
  logic spi_miso = 1'b0;
  logic tdo, spi_sck, spi_cs_n, spi_mosi;

  jspi_bridge u_dut (
    .tck(tck), .tap_reset(tap_reset), .dr_select(dr_select),
    .dr_capture(dr_capture), .dr_shift(dr_shift), .tdi(tdi), .tdo(tdo),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural flash: samples MOSI on SCK rise, drives MISO after SCK fall
  logic data[0:63];
  logic pat[0:63];
  logic rx[0:63];
  int   k = 0;
  int   sck_total = 0;
  logic cs_prev = 1'b1;

  always @(posedge spi_sck) sck_total++;

  always @(negedge spi_cs_n or posedge spi_cs_n or posedge spi_sck or negedge spi_sck) begin
    if (spi_cs_n) begin
      cs_prev = 1'b1;
    end else if (spi_sck) begin
      if (k < 64) rx[k] = spi_mosi;
      k++;
    end else if (cs_prev) begin
      cs_prev = 1'b0;
      k = 0;
      spi_miso = pat[0];
    end else begin
      spi_miso = (k < 64) ? pat[k] : 1'b0;
    end
  end

  task automatic step(input logic b, output logic cs_o, output logic tdo_o);
    @(negedge tck); #1;
    tdi = b;
    cs_o = spi_cs_n;
    @(posedge tck); #1;
    tdo_o = tdo;
  endtask

  task automatic send_len(input int len);
    logic c, o;
    for (int j = 31; j >= 0; j--) begin
      step(len[j], c, o);
      check("R3 length phase cs_n", c, 1'b1);
      check("R6 bypass during length", o, len[j]);
    end
  endtask

  task automatic frame(input int z, input int len, input int trail);
    logic c, o;
    int base;
    int bad;
    for (int i = 0; i < 64; i++) begin
      data[i] = ((i * 3 + z + len) % 5) < 2;
      pat[i]  = ((i * 7 + len) % 3) == 1;
    end
    base = sck_total;
    @(negedge tck); #1;
    tdi = 1'b0;
    dr_shift = 1'b1;
    for (int i = 0; i < z; i++) begin
      step(1'b0, c, o);
      check("R1 leading zero keeps cs_n high", c, 1'b1);
      check("R6 bypass of zero", o, 1'b0);
    end
    step(1'b1, c, o);
    check("R2 marker cs_n", c, 1'b1);
    check("R6 bypass of marker", o, 1'b1);
    send_len(len);
    for (int i = 0; i < len; i++) begin
      step(data[i], c, o);
      check("R4 cs_n low in transfer", c, 1'b0);
      check("R6 miso on tdo", o, pat[i]);
    end
    for (int i = 0; i < trail; i++) begin
      step(1'b0, c, o);
      check("R7 trailing cs_n high", c, 1'b1);
      check("R6 trailing bypass", o, 1'b0);
    end
    if (len == 0) check("R8 zero length sck edges", sck_total - base, 0);
    else          check("R2 R3 R4 sck edge count", sck_total - base, len);
    if (len > 0) begin
      check("R4 flash clock count", k, len);
      bad = 0;
      for (int i = 0; i < len; i++) if (rx[i] !== data[i]) bad++;
      check("R5 mosi bits received", bad, 0);
    end
    @(negedge tck); #1;
    dr_shift = 1'b0;
    tdi = 1'b0;
    @(negedge tck); #1;
    check("R9 idle cs_n after frame", spi_cs_n, 1'b1);
  endtask

  task automatic abort_test(input int kind);
    logic c, o;
    for (int i = 0; i < 64; i++) pat[i] = 1'b0;
    @(negedge tck); #1;
    dr_shift = 1'b1;
    step(1'b0, c, o);
    step(1'b1, c, o);
    send_len(20);
    for (int i = 0; i < 4; i++) step(1'b1, c, o);
    check("R4 cs_n low before abort", spi_cs_n, 1'b0);
    @(negedge tck); #1;
    if (kind == 0) dr_shift = 1'b0;
    else if (kind == 1) dr_select = 1'b0;
    else begin
      tap_reset = 1'b1;
      #1;
      check("R9 reset raises cs_n", spi_cs_n, 1'b1);
    end
    @(posedge tck);
    @(negedge tck); #1;
    check("R9 abort raises cs_n", spi_cs_n, 1'b1);
    check("R9 no sck after abort", spi_sck, 1'b0);
    tap_reset = 1'b0;
    dr_select = 1'b1;
    dr_shift = 1'b0;
    @(negedge tck); #1;
    frame(2, 3, 2);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge tck);
    #1;
    check("R1 reset cs_n", spi_cs_n, 1'b1);
    check("R1 reset sck", spi_sck, 1'b0);
    check("R6 reset tdo", tdo, 1'b0);
    tap_reset = 1'b0;
    dr_select = 1'b1;
    @(negedge tck); #1;
    dr_shift = 1'b1;
    tdi = 1'b1;
    @(negedge tck); #1;
    check("R6 bypass before capture", tdo, 1'b1);
    dr_shift = 1'b0;
    dr_capture = 1'b1;
    @(negedge tck); #1;
    dr_capture = 1'b0;
    tdi = 1'b0;
    check("R6 capture clears stage", tdo, 1'b0);
    @(negedge tck);
    for (int z = 0; z < 4; z++)
      for (int len = 0; len < 10; len++)
        frame(z, len, 3);
    frame(7, 40, 5);
    for (int kind = 0; kind < 3; kind++) abort_test(kind);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule